// File: doc/BRIEF.md
# SHA Message Padder

This block prepares a bit stream for a 512-bit-block SHA compression core. A start request taken while the block is idle captures a 64-bit length, counted in bits. Message words then arrive 32 bits at a time over a valid/enable handshake. The block passes those words downstream and counts the bits it has taken in. When the counted length is reached, it stops accepting input.

After the message, the block adds standard SHA padding: a single one bit, zeros up to bit 448 of a 512-bit block, and the captured length as two 32-bit words, most significant word first. The length is an exact bit count, so the message may end part-way through a word. In that case only the top bits of the last word are kept, and the one bit is placed directly below them inside the same word.

When fewer than 65 bits are free in the current block, the padding runs into one more block. Downstream, every 512-bit block appears as sixteen 32-bit words over a valid/ready handshake. A flag marks word 15 of the final block.

Top module: `sha_msg_padder`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `idle` is 1 and both `msgEnable` and `blkValid` are 0.
- R2: `msgLenBits` is captured only in a cycle where `idle` and `msgStart` are both high. While the block is active, `msgStart` pulses and changes to `msgLenBits` have no effect on the output words.
- R3: `msgEnable` is high only while the block is active, the output slot can take a word, and message bits remain. A word is taken only in a cycle where `msgValid` and `msgEnable` are both high. Exactly ceil(L/32) words are taken for a length of L bits.
- R4: Each message word that carries 32 message bits appears on `blkWord` unchanged and in arrival order. The earliest bit of the stream is bit 31.
- R5: If L mod 32 = k is nonzero, the last message word keeps its top k bits. Its remaining low bits are replaced by a one at bit 31-k followed by zeros.
- R6: If L is a multiple of 32, the word that follows the message is 0x80000000.
- R7: After the one bit, zero words fill the block up to word 13. Word 14 holds L[63:32] and word 15 holds L[31:0].
- R8: If the one bit lands in word 14 or 15 of a block, that block is finished with zeros. One more block follows, made of fourteen zero words and then the length. The total word count is 16 × (floor((L+64)/512)+1).
- R9: A zero-length message takes no input words. It produces one block: 0x80000000, fourteen zero words, and a zero length.
- R10: `blkLast` is high only together with `blkValid`, and only on word 15 of the final block of a message.
- R11: While `blkValid` is high and `blkReady` is low, `blkValid`, `blkWord` and `blkLast` hold their values into the next cycle.
- R12: In the cycle after the last word is taken downstream, `idle` is high and `blkValid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| msgStart | input | 1 | Start request, honoured while idle |
| msgLenBits | input | 64 | Message length in bits |
| idle | output | 1 | High when no message is in progress |
| msgData | input | 32 | Message word, earliest bit in bit 31 |
| msgValid | input | 1 | Message word offered |
| msgEnable | output | 1 | Block can take a message word |
| blkWord | output | 32 | Padded block word |
| blkValid | output | 1 | `blkWord` is valid |
| blkReady | input | 1 | Downstream takes `blkWord` |
| blkLast | output | 1 | Word 15 of the final block |

## Verification
The single output slot can refill in the same cycle that downstream drains it. A held word leaves on `blkReady`, and in that same edge either a new message word comes in through the input handshake or a padding word is generated. The bench provokes this by running `blkReady` and `msgValid` on different duty patterns, which are shifted for each length. It judges the result against a bit-level model of the padded stream: no word may be lost, repeated or changed while held. The length set includes the points where the pad bit falls at the end of a word, in the middle of a word, and in words 13, 14 and 15 of a block.

// File: rtl/sha_pad_pkg.sv
package sha_pad_pkg;

  // which source feeds the output slot
  typedef enum logic [2:0] {
    SRC_DATA,
    SRC_ONE,
    SRC_ZERO,
    SRC_LEN_HI,
    SRC_LEN_LO
  } wordSrcE;

  // strobes from control to datapath
  typedef struct packed {
    logic    capture;   // latch length, reset bit counter
    logic    consume;   // one input word taken
    logic    loadOut;   // write output slot
    wordSrcE src;
    logic    markLast;
  } padStrobeT;

endpackage

// File: rtl/sha_pad_dpath.sv
module sha_pad_dpath
  import sha_pad_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int LEN_W  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  padStrobeT         strobe,
  input  logic [LEN_W-1:0]  msgLenBits,
  input  logic [WORD_W-1:0] msgData,
  input  logic              blkReady,
  output logic              remZero,
  output logic              remPartial,
  output logic              slotFree,
  output logic [WORD_W-1:0] blkWord,
  output logic              blkValid,
  output logic              blkLast
);
  localparam int SH_W      = $clog2(WORD_W);
  localparam int LEN_WORDS = LEN_W / WORD_W;
  localparam logic [WORD_W-1:0] ALL_ONES = '1;
  localparam logic [WORD_W-1:0] TOP_BIT  = {1'b1, {(WORD_W-1){1'b0}}};

  logic [LEN_W-1:0]  lenReg;
  logic [LEN_W-1:0]  remBits;
  logic [WORD_W-1:0] lenWords [LEN_WORDS];
  logic [SH_W-1:0]   partK;
  logic [WORD_W-1:0] dataWord;
  logic [WORD_W-1:0] nextWord;

  // slice captured length into output words
  for (genvar g = 0; g < LEN_WORDS; g++) begin : g_lenSlice
    assign lenWords[g] = lenReg[g*WORD_W +: WORD_W];
  end

  assign remZero    = (remBits == '0);
  assign remPartial = !remZero && (remBits < LEN_W'(WORD_W));
  assign partK      = remBits[SH_W-1:0];
  assign slotFree   = !blkValid || blkReady;

  // final partial word: keep top bits, insert pad bit below them
  always_comb begin
    if (remPartial) dataWord = (msgData & ~(ALL_ONES >> partK)) | (TOP_BIT >> partK);
    else            dataWord = msgData;
  end

  always_comb begin
    unique case (strobe.src)
      SRC_DATA:   nextWord = dataWord;
      SRC_ONE:    nextWord = TOP_BIT;
      SRC_LEN_HI: nextWord = lenWords[LEN_WORDS-1];
      SRC_LEN_LO: nextWord = lenWords[0];
      default:    nextWord = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenReg  <= '0;
      remBits <= '0;
    end else if (strobe.capture) begin
      lenReg  <= msgLenBits;
      remBits <= msgLenBits;
    end else if (strobe.consume) begin
      remBits <= remPartial ? '0 : remBits - LEN_W'(WORD_W);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blkWord  <= '0;
      blkValid <= 1'b0;
      blkLast  <= 1'b0;
    end else if (strobe.loadOut) begin
      blkWord  <= nextWord;
      blkValid <= 1'b1;
      blkLast  <= strobe.markLast;
    end else if (blkReady) begin
      blkValid <= 1'b0;
      blkLast  <= 1'b0;
    end
  end

endmodule

// File: rtl/sha_pad_ctrl.sv
module sha_pad_ctrl
  import sha_pad_pkg::*;
#(
  parameter int BLK_WORDS = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      msgStart,
  input  logic      msgValid,
  input  logic      remZero,
  input  logic      remPartial,
  input  logic      slotFree,
  output logic      idle,
  output logic      msgEnable,
  output padStrobeT strobe
);
  localparam int IDX_W = $clog2(BLK_WORDS);
  localparam logic [IDX_W-1:0] IDX_LEN_HI = IDX_W'(BLK_WORDS - 2);
  localparam logic [IDX_W-1:0] IDX_LEN_LO = IDX_W'(BLK_WORDS - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_MSG, ST_PAD, ST_DRAIN} padStateE;

  padStateE        state, stateNext;
  logic [IDX_W-1:0] wordIdx;
  logic            oneDone;
  logic            lenHiSent;

  assign idle      = (state == ST_IDLE);
  assign msgEnable = (state == ST_MSG) && !remZero && slotFree;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (msgStart) begin
          strobe.capture = 1'b1;
          stateNext      = ST_MSG;
        end
      end
      ST_MSG: begin
        if (remZero) begin
          stateNext = ST_PAD;
        end else if (msgValid && slotFree) begin
          strobe.loadOut = 1'b1;
          strobe.consume = 1'b1;
          strobe.src     = SRC_DATA;
        end
      end
      ST_PAD: begin
        if (slotFree) begin
          strobe.loadOut = 1'b1;
          if (!oneDone) begin
            strobe.src = SRC_ONE;
          end else if (wordIdx == IDX_LEN_HI) begin
            strobe.src = SRC_LEN_HI;
          end else if (wordIdx == IDX_LEN_LO && lenHiSent) begin
            strobe.src      = SRC_LEN_LO;
            strobe.markLast = 1'b1;
            stateNext       = ST_DRAIN;
          end else begin
            strobe.src = SRC_ZERO;
          end
        end
      end
      default: begin
        if (slotFree) stateNext = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      wordIdx   <= '0;
      oneDone   <= 1'b0;
      lenHiSent <= 1'b0;
    end else begin
      state <= stateNext;
      if (strobe.capture) begin
        wordIdx   <= '0;
        oneDone   <= 1'b0;
        lenHiSent <= 1'b0;
      end else if (strobe.loadOut) begin
        wordIdx   <= (wordIdx == IDX_LEN_LO) ? '0 : wordIdx + 1'b1;
        lenHiSent <= (strobe.src == SRC_LEN_HI);
        if ((strobe.src == SRC_DATA && remPartial) || strobe.src == SRC_ONE)
          oneDone <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/sha_msg_padder.sv
module sha_msg_padder
  import sha_pad_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int LEN_W     = 64,
  parameter int BLK_WORDS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              msgStart,
  input  logic [LEN_W-1:0]  msgLenBits,
  output logic              idle,
  input  logic [WORD_W-1:0] msgData,
  input  logic              msgValid,
  output logic              msgEnable,
  output logic [WORD_W-1:0] blkWord,
  output logic              blkValid,
  input  logic              blkReady,
  output logic              blkLast
);
  padStrobeT strobe;
  logic      remZero;
  logic      remPartial;
  logic      slotFree;

  sha_pad_ctrl #(.BLK_WORDS(BLK_WORDS)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .msgStart   (msgStart),
    .msgValid   (msgValid),
    .remZero    (remZero),
    .remPartial (remPartial),
    .slotFree   (slotFree),
    .idle       (idle),
    .msgEnable  (msgEnable),
    .strobe     (strobe)
  );

  sha_pad_dpath #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .msgLenBits (msgLenBits),
    .msgData    (msgData),
    .blkReady   (blkReady),
    .remZero    (remZero),
    .remPartial (remPartial),
    .slotFree   (slotFree),
    .blkWord    (blkWord),
    .blkValid   (blkValid),
    .blkLast    (blkLast)
  );

endmodule

// File: rtl/sha_pad_chk.sv
module sha_pad_chk #(
  parameter int WORD_W    = 32,
  parameter int BLK_WORDS = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              idle,
  input logic              msgEnable,
  input logic [WORD_W-1:0] blkWord,
  input logic              blkValid,
  input logic              blkReady,
  input logic              blkLast
);
  localparam int CNT_W = $clog2(BLK_WORDS);

  logic [CNT_W-1:0] outCnt;
  logic             outFire;

  assign outFire = blkValid && blkReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outCnt <= '0;
    else if (outFire) outCnt <= (outCnt == CNT_W'(BLK_WORDS - 1)) ? '0 : outCnt + 1'b1;
  end

  // R3
  no_enable_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    idle |-> !msgEnable);

  // R11
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (blkValid && !blkReady) |=> (blkValid && $stable(blkWord) && $stable(blkLast)));

  // R10
  last_has_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    blkLast |-> blkValid);

  // R10
  last_word_pos_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outFire && blkLast) |-> (outCnt == CNT_W'(BLK_WORDS - 1)));

  // R12
  idle_after_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outFire && blkLast) |=> (idle && !blkValid));

endmodule

bind sha_msg_padder sha_pad_chk #(.WORD_W(WORD_W), .BLK_WORDS(BLK_WORDS)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .idle      (idle),
  .msgEnable (msgEnable),
  .blkWord   (blkWord),
  .blkValid  (blkValid),
  .blkReady  (blkReady),
  .blkLast   (blkLast)
);

// File: tb/sha_msg_padder_bench.sv
`timescale 1ns/1ps
module sha_msg_padder_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        msgStart = 1'b0;
  logic [63:0] msgLenBits = '0;
  logic        idle;
  logic [31:0] msgData = '0;
  logic        msgValid = 1'b0;
  logic        msgEnable;
  logic [31:0] blkWord;
  logic        blkValid;
  logic        blkReady = 1'b0;
  logic        blkLast;

  int testsRun = 0;
  int testsFailed = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  sha_msg_padder u_sha_msg_padder (
    .clk(clk), .rstN(rstN), .msgStart(msgStart), .msgLenBits(msgLenBits),
    .idle(idle), .msgData(msgData), .msgValid(msgValid), .msgEnable(msgEnable),
    .blkWord(blkWord), .blkValid(blkValid), .blkReady(blkReady), .blkLast(blkLast)
  );

  // stimulus lengths and expected block counts (R4..R9)
  localparam int NVEC = 13;
  localparam logic [63:0] LENS [NVEC] = '{64'd0, 64'd1, 64'd31, 64'd32, 64'd33, 64'd416,
                                          64'd447, 64'd448, 64'd479, 64'd480, 64'd511,
                                          64'd512, 64'd1000};
  localparam int BLKS [NVEC] = '{1, 1, 1, 1, 1, 1, 1, 2, 2, 2, 2, 2, 3};

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] srcWord(input int seed, input int n);
    return (32'(seed) * 32'h9E3779B1) ^ (32'(n) * 32'h01000193 + 32'(n));
  endfunction

  // bit-level model of the padded stream
  function automatic logic [31:0] expWord(input logic [63:0] len, input int seed, input int idx);
    logic [31:0] w;
    longint L = longint'(len);
    longint total = ((L + 64) / 512 + 1) * 512;
    for (int j = 0; j < 32; j++) begin
      longint pos = longint'(idx) * 32 + j;
      logic b;
      logic [31:0] sw;
      if (pos < L) begin
        sw = srcWord(seed, int'(pos / 32));
        b = sw[31 - int'(pos % 32)];
      end else if (pos == L) b = 1'b1;
      else if (pos >= total - 64) b = len[63 - int'(pos - (total - 64))];
      else b = 1'b0;
      w[31 - j] = b;
    end
    return w;
  endfunction

  function automatic string regionReq(input logic [63:0] len, input int idx, input int nWords);
    longint L = longint'(len);
    if (L == 0) return "R9";
    if (idx >= nWords - 2) return "R7";
    if (longint'(idx) * 32 + 32 <= L) return "R4";
    if (longint'(idx) * 32 < L) return "R5";
    if (longint'(idx) * 32 == L) return "R6";
    if (idx >= nWords - 16) return "R8";
    return "R7";
  endfunction

  task automatic runMsg(input logic [63:0] len, input int blks, input int vi);
    int nIn = int'((len + 64'd31) / 64'd32);
    int fed = 0;
    int nGot = 0;
    int nLast = 0;
    int lastAt = -1;
    int badCnt = 0;
    int firstBad = -1;
    logic [31:0] firstAct = '0;
    int stableBad = 0;
    int idleEnBad = 0;
    bit prevHeld = 0;
    logic [31:0] heldW = '0;
    bit done = 0;
    int seed = vi * 17 + 5;

    @(negedge clk);
    check(idle === 1'b1, "R2", "idle before start", longint'(idle), 1);
    msgLenBits = len;
    msgStart = 1'b1;
    @(negedge clk);
    msgStart = 1'b0;
    msgLenBits = ~len;  // must not matter (R2)
    for (int cyc = 0; cyc < 5000 && !done; cyc++) begin
      msgValid = ((cyc + vi) % 3) != 0;
      msgData  = srcWord(seed, fed);
      blkReady = ((cyc * 7 + vi) % 4) != 0;
      msgStart = (cyc == 3);  // ignored while active (R2)
      #1;
      if (idle && msgEnable) idleEnBad++;
      if (prevHeld && !(blkValid && blkWord == heldW)) stableBad++;
      if (msgValid && msgEnable) fed++;
      if (blkValid && blkReady) begin
        if (blkWord !== expWord(len, seed, nGot)) begin
          if (firstBad < 0) begin firstBad = nGot; firstAct = blkWord; end
          badCnt++;
        end
        if (blkLast) begin nLast++; lastAt = nGot; done = 1; end
        nGot++;
      end
      prevHeld = blkValid && !blkReady;
      heldW = blkWord;
      @(negedge clk);
    end
    msgValid = 1'b0;
    msgStart = 1'b0;
    blkReady = 1'b0;
    #1;
    check(done, "R10", $sformatf("len %0d finished", len), longint'(done), 1);
    check(idle === 1'b1 && blkValid === 1'b0, "R12", $sformatf("len %0d idle after last", len),
          longint'({idle, blkValid}), 2);
    check(fed == nIn, "R3", $sformatf("len %0d words taken", len), fed, nIn);
    check(nGot == blks * 16, "R8", $sformatf("len %0d output words", len), nGot, blks * 16);
    if (firstBad >= 0)
      check(0, regionReq(len, firstBad, nGot), $sformatf("len %0d word %0d", len, firstBad),
            longint'(firstAct), longint'(expWord(len, seed, firstBad)));
    else
      check(1, "R7", "content", 0, 0);
    check(nLast == 1 && lastAt == nGot - 1, "R10", $sformatf("len %0d last position", len),
          lastAt, nGot - 1);
    check(stableBad == 0, "R11", $sformatf("len %0d held word", len), stableBad, 0);
    check(idleEnBad == 0, "R3", $sformatf("len %0d enable while idle", len), idleEnBad, 0);
  endtask

  initial begin : watchdog
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    testsFailed++;
    testsRun++;
    $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, 150000);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #1;
    // R1: during reset
    check(idle === 1'b1 && msgEnable === 1'b0 && blkValid === 1'b0, "R1", "in reset",
          longint'({idle, msgEnable, blkValid}), 4);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(idle === 1'b1 && msgEnable === 1'b0 && blkValid === 1'b0, "R1", "after reset",
          longint'({idle, msgEnable, blkValid}), 4);

    // R3: offered data while idle is not taken
    msgValid = 1'b1;
    msgData = 32'hDEADBEEF;
    #1;
    check(msgEnable === 1'b0, "R3", "enable while idle", longint'(msgEnable), 0);
    @(negedge clk);
    msgValid = 1'b0;

    for (int v = 0; v < NVEC; v++) runMsg(LENS[v], BLKS[v], v);

    // reset in mid-message
    @(negedge clk);
    msgLenBits = 64'd1000;
    msgStart = 1'b1;
    @(negedge clk);
    msgStart = 1'b0;
    msgValid = 1'b1;
    blkReady = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b0;
    #1;
    check(idle === 1'b1 && msgEnable === 1'b0 && blkValid === 1'b0, "R1", "mid-message reset",
          longint'({idle, msgEnable, blkValid}), 4);
    msgValid = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    runMsg(64'd33, 1, 20);
    runMsg(64'd0, 1, 21);  // R9 after recovery

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule